// File: doc/BRIEF.md
# Dual-Bank Waveform Playback Memory

This block replays a stored, looping sample sequence as a two-lane stream. Even-indexed samples live in one RAM bank and odd-indexed samples in a second bank. Each cycle the block emits one even sample and one odd sample side by side. Each bank has its own load controller, driven through a small register port. Software fills the two banks in whichever order it likes. Each bank begins replaying by itself as soon as its load sequence is committed, but the two banks are not aligned at that point.

Alignment comes from a shared synchronising reset. The reset bit in either bank's control register holds both read pointers at address 0. When the combined bit is cleared, both pointers leave address 0 on the same clock edge. A loop-end register sets the sequence length for both banks. A source select chooses between the replayed waveform and a two-lane direct data input, and it is set to the direct input out of reset.

Top module: `wave_bank_player`

## Requirements
- R1: After reset, `wave_out` is 0 and `wr_err` is 0. The source select starts at direct (1), so one cycle later `wave_out` equals `direct_in`. The loop end starts at 1023.
- R2: Bank base addresses are 0x10 (even) and 0x20 (odd). Writing base+1 sets the bank's write pointer. Each write to base+2 stores `cfg_wdata` at the write pointer and then increments it. A write to base+3 commits the load. From the first committed address 0 onward, the bank's samples appear in order on its lane.
- R3: Loading the odd bank before the even bank gives the same synchronised stream as loading them in the opposite order.
- R4: After a commit, a bank replays with no synchronising reset. Sample 0 appears on its lane two cycles after the commit write edge.
- R5: Bit 0 of either control register (0x10 or 0x20) is the synchronising reset. While this bit is 1 in either register, both lanes repeat sample 0 from the third cycle after the setting edge.
- R6: After the combined reset bit goes from 1 to 0, both lanes show sample k exactly k+2 cycles after the clearing edge, in lockstep.
- R7: Register 0x30, bits 9:0, holds the loop end E. Both banks wrap from address E back to address 0, so the period is E+1.
- R8: Register 0x31, bit 0, is the source select: 1 means direct input, 0 means memory. In memory mode, `wave_out[13:0]` is the even sample and `wave_out[27:14]` is the odd sample, with a latency of one register stage after the RAM read. In direct mode, `wave_out` equals `direct_in` one cycle later.
- R9: Bit 1 of a control register is the run flag. While run is 1, writes to that bank's base+1, base+2 and base+3 are ignored and leave the stored samples unchanged. Such a write also sets the sticky `wr_err` bit for that bank (bit 0 = even, bit 1 = odd).
- R10: A bank that is being loaded, or has never been committed, drives 0 on its lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 14 | Register write data |
| direct_in | input | 28 | Direct two-lane sample input |
| wave_out | output | 28 | Output samples: odd lane high, even lane low |
| wr_err | output | 2 | Sticky flags for load writes blocked by run mode, one per bank |

## Verification
The stream is first checked with only the even bank loaded, which separates free-running start-up from synchronised playback and shows that the unloaded lane stays at zero. The banks are then loaded in both orders, with different sample sets and loop lengths. The synchronising reset is driven from each register in turn, so a design that ties the sync to one bank, or that wraps at the wrong address, gives a visibly different lane pair. Blocked writes in run mode are followed by a fresh sync and a full period of readback, which shows whether the stored samples survived. Direct mode is checked with changing input words to confirm the one-cycle bypass.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

  localparam int unsigned NUM_BANKS = 2;

  localparam logic [7:0] OFS_CTRL  = 8'h0;
  localparam logic [7:0] OFS_WPTR  = 8'h1;
  localparam logic [7:0] OFS_WDATA = 8'h2;
  localparam logic [7:0] OFS_DONE  = 8'h3;

  localparam logic [7:0] ADDR_LOOP_END = 8'h30;
  localparam logic [7:0] ADDR_SRC_SEL  = 8'h31;

  typedef enum logic [0:0] {LD_IDLE, LD_FILL} ld_state_e;

  typedef struct packed {
    logic run;
    logic swrst;
  } bank_ctrl_t;

  typedef struct packed {
    logic set_ptr;
    logic put_data;
    logic done;
  } bank_wr_t;

  // Bank 0 (even) sits at 0x10, bank 1 (odd) at 0x20.
  function automatic logic [7:0] bank_base(input int unsigned idx);
    return 8'((idx + 1) * 32'd16);
  endfunction

  // Loop pointer step: wrap to zero once the loop end is reached.
  function automatic logic [15:0] loop_step(input logic [15:0] cur,
                                            input logic [15:0] last);
    return (cur >= last) ? 16'd0 : cur + 16'd1;
  endfunction

endpackage

// File: rtl/wbp_regs.sv
module wbp_regs
  import wbp_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned PTR_W  = 10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we,
  input  logic [7:0]                           addr,
  input  logic [DATA_W-1:0]                    wdata,
  output bank_ctrl_t [NUM_BANKS-1:0]           ctrl,
  output bank_wr_t   [NUM_BANKS-1:0]           wr,
  output logic [PTR_W-1:0]                     loop_end,
  output logic                                 src_direct
);

  logic unused_bits;
  assign unused_bits = ^wdata;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_regs
    localparam logic [7:0] BASE = bank_base(b);
    bank_ctrl_t ctrl_q;
    logic       ctrl_hit;

    assign ctrl_hit = we && (addr == BASE + OFS_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
      end else if (ctrl_hit) begin
        ctrl_q.run   <= wdata[1];
        ctrl_q.swrst <= wdata[0];
      end
    end

    assign ctrl[b] = ctrl_q;
    assign wr[b].set_ptr  = we && (addr == BASE + OFS_WPTR);
    assign wr[b].put_data = we && (addr == BASE + OFS_WDATA);
    assign wr[b].done     = we && (addr == BASE + OFS_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_end   <= '1;
      src_direct <= 1'b1;
    end else if (we) begin
      if (addr == ADDR_LOOP_END) loop_end   <= wdata[PTR_W-1:0];
      if (addr == ADDR_SRC_SEL)  src_direct <= wdata[0];
    end
  end

endmodule

// File: rtl/wbp_bank.sv
module wbp_bank
  import wbp_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned PTR_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                hold,
  input  logic [PTR_W-1:0]    loop_end,
  input  bank_wr_t            wr,
  input  logic [SAMPLE_W-1:0] wdata,
  output logic [SAMPLE_W-1:0] lane,
  output logic                err,
  output logic [PTR_W-1:0]    rd_ptr,
  output logic                playing
);

  localparam int unsigned DEPTH = 1 << PTR_W;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  ld_state_e           st;
  logic [PTR_W-1:0]    wptr;
  logic                loaded;
  logic                q_valid;
  logic [SAMPLE_W-1:0] rd_q;

  // Named events for the assertions.
  logic wr_any, wr_blocked, wr_ok, fill_evt, done_evt;
  assign wr_any     = wr.set_ptr | wr.put_data | wr.done;
  assign wr_blocked = wr_any & run;
  assign wr_ok      = wr_any & ~run;
  assign fill_evt   = wr_ok & wr.put_data;
  assign done_evt   = wr_ok & wr.done & (st == LD_FILL);

  function automatic logic [PTR_W-1:0] next_rd(input logic [PTR_W-1:0] cur,
                                               input logic [PTR_W-1:0] last);
    logic [15:0] nxt;
    nxt = loop_step(16'(cur), 16'(last));
    return nxt[PTR_W-1:0];
  endfunction

  // Load controller
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= LD_IDLE;
      wptr   <= '0;
      loaded <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (wr_blocked) err <= 1'b1;
      if (wr_ok && wr.set_ptr) wptr <= wdata[PTR_W-1:0];
      if (fill_evt) begin
        wptr   <= wptr + 1'b1;
        st     <= LD_FILL;
        loaded <= 1'b0;
      end
      if (done_evt) begin
        st     <= LD_IDLE;
        loaded <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_evt) mem[wptr] <= wdata;
  end

  // Read side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= loaded;
      if (hold || !loaded) rd_ptr <= '0;
      else                 rd_ptr <= next_rd(rd_ptr, loop_end);
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[rd_ptr];
  end

  assign lane    = q_valid ? rd_q : '0;
  assign playing = loaded;

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !hold && rd_ptr >= loop_end) |=> (rd_ptr == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !hold && !fill_evt && rd_ptr < loop_end) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

  p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> (err && $stable(wptr)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |=> (lane == '0));

endmodule

// File: rtl/wbp_outmux.sv
module wbp_outmux #(
  parameter int unsigned SAMPLE_W = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_direct,
  input  logic [SAMPLE_W-1:0]   lane_even,
  input  logic [SAMPLE_W-1:0]   lane_odd,
  input  logic [2*SAMPLE_W-1:0] direct_in,
  output logic [2*SAMPLE_W-1:0] out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          out <= '0;
    else if (sel_direct) out <= direct_in;
    else                 out <= {lane_odd, lane_even};
  end

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_direct |=> (out == $past(direct_in)));

  p_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_direct |=> (out[SAMPLE_W-1:0] == $past(lane_even)));

endmodule

// File: rtl/wave_bank_player.sv
module wave_bank_player
  import wbp_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned PTR_W    = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_addr,
  input  logic [SAMPLE_W-1:0]   cfg_wdata,
  input  logic [2*SAMPLE_W-1:0] direct_in,
  output logic [2*SAMPLE_W-1:0] wave_out,
  output logic [1:0]            wr_err
);

  bank_ctrl_t [NUM_BANKS-1:0] ctrl;
  bank_wr_t   [NUM_BANKS-1:0] wr;
  logic [PTR_W-1:0]           loop_end;
  logic                       src_direct;
  logic                       sync_hold;

  logic [SAMPLE_W-1:0] lane   [NUM_BANKS];
  logic [PTR_W-1:0]    rd_ptr [NUM_BANKS];
  logic [NUM_BANKS-1:0] playing;

  wbp_regs #(.DATA_W(SAMPLE_W), .PTR_W(PTR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .ctrl       (ctrl),
    .wr         (wr),
    .loop_end   (loop_end),
    .src_direct (src_direct)
  );

  // Either bank's reset bit holds every bank.
  assign sync_hold = ctrl[0].swrst | ctrl[1].swrst;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wbp_bank #(.SAMPLE_W(SAMPLE_W), .PTR_W(PTR_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl[b].run),
      .hold     (sync_hold),
      .loop_end (loop_end),
      .wr       (wr[b]),
      .wdata    (cfg_wdata),
      .lane     (lane[b]),
      .err      (wr_err[b]),
      .rd_ptr   (rd_ptr[b]),
      .playing  (playing[b])
    );
  end

  wbp_outmux #(.SAMPLE_W(SAMPLE_W)) u_outmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_direct (src_direct),
    .lane_even  (lane[0]),
    .lane_odd   (lane[1]),
    .direct_in  (direct_in),
    .out        (wave_out)
  );

  p_hold_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hold |=> (rd_ptr[0] == '0 && rd_ptr[1] == '0));

  p_lockstep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&playing && !sync_hold && rd_ptr[0] == rd_ptr[1])
      |=> (!(&playing) || rd_ptr[0] == rd_ptr[1]));

endmodule

// File: tb/wave_bank_player_tb_top.sv
module wave_bank_player_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [13:0] cfg_wdata = '0;
  logic [27:0] direct_in = '0;
  logic [27:0] wave_out;
  logic [1:0]  wr_err;

  int total = 0;
  int bad = 0;

  logic [13:0] ev [6];
  logic [13:0] od [6];

  always #5 clk = ~clk;

  wave_bank_player dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .direct_in(direct_in), .wave_out(wave_out), .wr_err(wr_err)
  );

  task automatic chk(input string tag, input logic [27:0] act, input logic [27:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [13:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_bank(input int b, input int n, input bit odd);
    logic [7:0] base;
    base = 8'((b + 1) * 16);
    cfg_write(base + 8'd1, 14'd0);
    for (int i = 0; i < n; i++) cfg_write(base + 8'd2, odd ? od[i] : ev[i]);
    cfg_write(base + 8'd3, 14'd0);
  endtask

  // Called right after the clearing write; index 0 shows two cycles later.
  task automatic check_stream(input string tag, input int len, input int n);
    repeat (2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      chk(tag, wave_out, {od[k % len], ev[k % len]});
      @(negedge clk);
    end
  endtask

  task automatic sync_via(input logic [7:0] reg_a, input int len);
    cfg_write(reg_a, 14'd3);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R5 hold at sample 0", wave_out, {od[0], ev[0]});
      @(negedge clk);
    end
    cfg_write(reg_a, 14'd2);
  endtask

  task automatic t_reset;
    chk("R1 reset output", wave_out, 28'h0);
    chk("R1 reset err", {26'h0, wr_err}, 28'h0);
    direct_in = 28'h5A5_1234;
    @(negedge clk);
    chk("R1 default direct", wave_out, 28'h5A5_1234);
  endtask

  task automatic t_round1;
    for (int i = 0; i < 6; i++) begin
      ev[i] = 14'h0A00 + 14'(i);
      od[i] = 14'h1500 + 14'(i * 7);
    end
    cfg_write(8'h30, 14'd5);
    cfg_write(8'h31, 14'd0);
    load_bank(0, 6, 1'b0);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      chk("R4/R10 even plays alone", wave_out, {14'h0, ev[k % 6]});
      @(negedge clk);
    end
    load_bank(1, 6, 1'b1);
    cfg_write(8'h10, 14'd2);
    cfg_write(8'h20, 14'd2);
    sync_via(8'h10, 6);
    check_stream("R6/R7/R2 aligned stream even-first", 6, 14);
  endtask

  task automatic t_blocked;
    cfg_write(8'h11, 14'd0);
    chk("R9 err even", {26'h0, wr_err}, 28'h1);
    cfg_write(8'h22, 14'h3FFF);
    chk("R9 err odd", {26'h0, wr_err}, 28'h3);
    cfg_write(8'h13, 14'd0);
    sync_via(8'h20, 6);
    check_stream("R9/R5 contents kept, sync from odd reg", 6, 7);
    chk("R9 err sticky", {26'h0, wr_err}, 28'h3);
  endtask

  task automatic t_round2;
    cfg_write(8'h10, 14'd0);
    cfg_write(8'h20, 14'd0);
    for (int i = 0; i < 6; i++) begin
      ev[i] = 14'h3300 - 14'(i * 5);
      od[i] = 14'h0040 + 14'(i * 11);
    end
    cfg_write(8'h30, 14'd3);
    cfg_write(8'h21, 14'd0);
    cfg_write(8'h22, od[0]);
    repeat (2) @(negedge clk);
    chk("R10 odd lane zero during load", {14'h0, wave_out[27:14]}, 28'h0);
    for (int i = 1; i < 4; i++) cfg_write(8'h22, od[i]);
    cfg_write(8'h23, 14'd0);
    load_bank(0, 4, 1'b0);
    cfg_write(8'h20, 14'd2);
    cfg_write(8'h10, 14'd2);
    sync_via(8'h20, 4);
    check_stream("R3/R7 odd-first stream, period 4", 4, 10);
  endtask

  task automatic t_direct;
    cfg_write(8'h31, 14'd1);
    direct_in = 28'hABC_DEF0;
    @(negedge clk);
    chk("R8 direct word 1", wave_out, 28'hABC_DEF0);
    direct_in = 28'h0123_456;
    @(negedge clk);
    chk("R8 direct word 2", wave_out, 28'h0123_456);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_round1();
    t_blocked();
    t_round2();
    t_direct();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule